// File: doc/BRIEF.md
# Dual Address Generation Unit

This block forms the data-memory addresses for a signal-processing core that reads or writes two memory words per instruction. It keeps five pointer registers, one offset register and one modifier register. The last pointer doubles as the stack pointer. Two address ports work side by side in every cycle. Each port names a pointer, an addressing mode and a short 6-bit direct field. Each port then presents an address at once, and it can write a modified pointer back at the next clock edge.

The two address ALUs are not equal. The port 0 ALU can wrap pointer updates inside a circular buffer whose length comes from the modifier register. The port 1 ALU always updates linearly. A separate load port writes any pointer, the offset or the modifier. Memory arrays and instruction decode sit outside the block.

Mode codes, which apply to both ports: 0 plain, 1 post-increment, 2 post-decrement, 3 post-add-offset, 4 indexed, 5 push, 6 pop, 7 short direct.

Top module: `dual_agu`

## Requirements
- R1: After reset every pointer and the offset read as 0 and the modifier reads 0xFFFF (linear mode).
- R2: When `ld_en` is high, `ld_data` is written at the clock edge into pointer `ld_sel` for codes 0–4, into the offset for code 5 and into the modifier for code 6. Code 7 changes nothing. In the same cycle a load takes priority over any port update of the same register.
- R3: In modes 1, 2 and 3 the address is the pointer value before the update. The pointer then becomes pointer+1, pointer−1 or pointer+offset (the offset is signed 16-bit, modulo 2^16) at the next edge.
- R4: In mode 4 the address is pointer+offset and no register changes.
- R5: Push (mode 5) outputs stack pointer−1 and stores it. Pop (mode 6) outputs the stack pointer and stores stack pointer+1. Both modes ignore the port's pointer select and never wrap.
- R6: Mode 7 outputs the 6-bit short field zero-extended to 16 bits and changes no register. Mode 0 outputs the selected pointer and changes nothing.
- R7: On port 0, when the modifier M is not 0xFFFF, modes 1–3 wrap inside the aligned block of size 2^k (the smallest power of two ≥ M+1) that holds the pointer. The offset within the block is stepped, then reduced once by M+1 if it exceeds M, or raised once by M+1 if it is negative.
- R8: Port 1 updates linearly whatever the modifier holds.
- R9: When both ports update the same register in one cycle, the value from port 0 is kept.
- R10: A port whose enable is low outputs address 0 and updates nothing. A pointer select of 5–7 in modes 0–4 also gives address 0 and no update.
- R11: Both ports issue independent addresses in the same cycle, each computed from the register values of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 3 | Load target: 0–4 pointer, 5 offset, 6 modifier |
| ld_data | input | 16 | Load value |
| p0_en | input | 1 | Port 0 active |
| p0_sel | input | 3 | Port 0 pointer select |
| p0_mode | input | 3 | Port 0 addressing mode |
| p0_short | input | 6 | Port 0 short direct address |
| p1_en | input | 1 | Port 1 active |
| p1_sel | input | 3 | Port 1 pointer select |
| p1_mode | input | 3 | Port 1 addressing mode |
| p1_short | input | 6 | Port 1 short direct address |
| p0_addr | output | 16 | Port 0 address (modulo-capable ALU) |
| p1_addr | output | 16 | Port 1 address (linear ALU) |

## Verification
The properties assume reset is released synchronously and that ports and loads are driven only between clock edges. The post-increment, push and conflict properties also assume that nothing else writes the register under test in that cycle, so each one is qualified by a quiet load port or an idle other port. The stimulus sets inputs half a cycle after the edge. Its random phase mixes loads, out-of-range selects and modifier values both inside and outside the pointer's block, and the reference model applies the same single-correction wrap rule from R7, so the outcome is predicted even for pointers lying outside their buffer.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_PLAIN = 3'd0,
    AM_INC   = 3'd1,
    AM_DEC   = 3'd2,
    AM_OFF   = 3'd3,
    AM_IDX   = 3'd4,
    AM_PUSH  = 3'd5,
    AM_POP   = 3'd6,
    AM_SHORT = 3'd7
  } agu_mode_e;
endpackage

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int AW   = 16,
  parameter int NPTR = 5,
  localparam int IW  = $clog2(NPTR),
  localparam int LW  = $clog2(NPTR + 2)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_en,
  input  logic [LW-1:0]            ld_sel,
  input  logic [AW-1:0]            ld_data,
  input  logic                     wr0_en,
  input  logic [IW-1:0]            wr0_idx,
  input  logic [AW-1:0]            wr0_val,
  input  logic                     wr1_en,
  input  logic [IW-1:0]            wr1_idx,
  input  logic [AW-1:0]            wr1_val,
  output logic [NPTR-1:0][AW-1:0]  ptrs,
  output logic [AW-1:0]            offset,
  output logic [AW-1:0]            modifier
);
  localparam logic [LW-1:0] SEL_OFF = LW'(NPTR);
  localparam logic [LW-1:0] SEL_MOD = LW'(NPTR + 1);

  logic [AW-1:0] ptr_q  [NPTR];
  logic [AW-1:0] ptr_d  [NPTR];
  logic          ptr_we [NPTR];
  logic [AW-1:0] off_q, mod_q;
  logic          off_we, mod_we;

  // next state: port 1, then port 0 over it, then the load over both
  always_comb begin
    for (int i = 0; i < NPTR; i++) begin
      ptr_we[i] = 1'b0;
      ptr_d[i]  = ptr_q[i];
      if (wr1_en && wr1_idx == IW'(i)) begin
        ptr_we[i] = 1'b1;
        ptr_d[i]  = wr1_val;
      end
      if (wr0_en && wr0_idx == IW'(i)) begin
        ptr_we[i] = 1'b1;
        ptr_d[i]  = wr0_val;
      end
      if (ld_en && ld_sel == LW'(i)) begin
        ptr_we[i] = 1'b1;
        ptr_d[i]  = ld_data;
      end
    end
    off_we = ld_en && (ld_sel == SEL_OFF);
    mod_we = ld_en && (ld_sel == SEL_MOD);
  end

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ptr_q[g] <= '0;
      else if (ptr_we[g])  ptr_q[g] <= ptr_d[g];
    end
    assign ptrs[g] = ptr_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= '0;
    else if (off_we) off_q <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mod_q <= '1;
    else if (mod_we) mod_q <= ld_data;
  end

  assign offset   = off_q;
  assign modifier = mod_q;
endmodule

// File: rtl/agu_addr_alu.sv
module agu_addr_alu
  import agu_pkg::*;
#(
  parameter int AW        = 16,
  parameter int NPTR      = 5,
  parameter int SW        = 6,
  parameter bit MODULO_EN = 1'b1,
  localparam int IW       = $clog2(NPTR)
) (
  input  logic           en,
  input  logic [IW-1:0]  sel,
  input  agu_mode_e      mode,
  input  logic           sel_ok,
  input  logic [AW-1:0]  ptr,
  input  logic [AW-1:0]  sp,
  input  logic [AW-1:0]  offset,
  input  logic [AW-1:0]  modifier,
  input  logic [SW-1:0]  short_addr,
  output logic [AW-1:0]  addr,
  output logic           wr_en,
  output logic [IW-1:0]  wr_idx,
  output logic [AW-1:0]  wr_val
);
  localparam logic [IW-1:0] SP_IDX = IW'(NPTR - 1);

  logic signed [AW+1:0] delta, rel, sum, size;
  logic [AW-1:0]        mask, lin_val, wrap_val, post_val;
  logic                 post_mode, wrap_on;

  always_comb begin
    post_mode = (mode == AM_INC) || (mode == AM_DEC) || (mode == AM_OFF);
    unique case (mode)
      AM_INC:  delta = 'sd1;
      AM_DEC:  delta = -'sd1;
      default: delta = {{2{offset[AW-1]}}, offset};
    endcase
    lin_val = ptr + delta[AW-1:0];
    // block mask: all ones up to the top set bit of the modifier
    mask[AW-1] = modifier[AW-1];
    for (int b = AW - 2; b >= 0; b--) mask[b] = mask[b+1] | modifier[b];
    rel  = {2'b00, ptr & mask};
    size = {2'b00, modifier} + 'sd1;
    sum  = rel + delta;
    if (sum > $signed({2'b00, modifier})) sum = sum - size;
    else if (sum < 0)                     sum = sum + size;
    wrap_val = (ptr & ~mask) | (sum[AW-1:0] & mask);
    wrap_on  = MODULO_EN && (modifier != '1);
  end

  if (MODULO_EN) begin : g_mod
    assign post_val = wrap_on ? wrap_val : lin_val;
  end else begin : g_lin
    assign post_val = lin_val;
  end

  always_comb begin
    addr   = '0;
    wr_en  = 1'b0;
    wr_idx = sel;
    wr_val = post_val;
    if (en) begin
      unique case (mode)
        AM_PLAIN, AM_INC, AM_DEC, AM_OFF: begin
          addr  = sel_ok ? ptr : '0;
          wr_en = sel_ok && post_mode;
        end
        AM_IDX:   addr = sel_ok ? ptr + offset : '0;
        AM_PUSH: begin
          addr   = sp - 1'b1;
          wr_en  = 1'b1;
          wr_idx = SP_IDX;
          wr_val = sp - 1'b1;
        end
        AM_POP: begin
          addr   = sp;
          wr_en  = 1'b1;
          wr_idx = SP_IDX;
          wr_val = sp + 1'b1;
        end
        default:  addr = AW'(short_addr);
      endcase
    end
  end
endmodule

// File: rtl/dual_agu.sv
module dual_agu
  import agu_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NPTR = 5,
  parameter int SW   = 6,
  localparam int IW  = $clog2(NPTR),
  localparam int LW  = $clog2(NPTR + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_en,
  input  logic [LW-1:0]  ld_sel,
  input  logic [AW-1:0]  ld_data,
  input  logic           p0_en,
  input  logic [IW-1:0]  p0_sel,
  input  logic [2:0]     p0_mode,
  input  logic [SW-1:0]  p0_short,
  input  logic           p1_en,
  input  logic [IW-1:0]  p1_sel,
  input  logic [2:0]     p1_mode,
  input  logic [SW-1:0]  p1_short,
  output logic [AW-1:0]  p0_addr,
  output logic [AW-1:0]  p1_addr
);
  logic [NPTR-1:0][AW-1:0] ptrs_q;
  logic [AW-1:0]           offset_q, modifier_q;
  logic [AW-1:0]           ptr_p [2];
  logic                    ok_p  [2];
  logic [IW-1:0]           sel_p [2];
  logic                    wr_en [2];
  logic [IW-1:0]           wr_idx[2];
  logic [AW-1:0]           wr_val[2];
  logic [AW-1:0]           addr_p[2];
  logic                    en_p  [2];
  agu_mode_e               mode_p[2];
  logic [SW-1:0]           short_p[2];

  assign sel_p[0] = p0_sel;  assign sel_p[1] = p1_sel;
  assign en_p[0]  = p0_en;   assign en_p[1]  = p1_en;
  assign mode_p[0] = agu_mode_e'(p0_mode);
  assign mode_p[1] = agu_mode_e'(p1_mode);
  assign short_p[0] = p0_short;  assign short_p[1] = p1_short;

  agu_regfile #(.AW(AW), .NPTR(NPTR)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .wr0_en(wr_en[0]), .wr0_idx(wr_idx[0]), .wr0_val(wr_val[0]),
    .wr1_en(wr_en[1]), .wr1_idx(wr_idx[1]), .wr1_val(wr_val[1]),
    .ptrs(ptrs_q), .offset(offset_q), .modifier(modifier_q)
  );

  for (genvar p = 0; p < 2; p++) begin : g_port
    always_comb begin
      ptr_p[p] = '0;
      ok_p[p]  = 1'b0;
      for (int i = 0; i < NPTR; i++) begin
        if (sel_p[p] == IW'(i)) begin
          ptr_p[p] = ptrs_q[i];
          ok_p[p]  = 1'b1;
        end
      end
    end

    // port 0 owns the modulo-capable ALU, port 1 the linear one
    agu_addr_alu #(.AW(AW), .NPTR(NPTR), .SW(SW), .MODULO_EN(p == 0)) u_alu (
      .en(en_p[p]), .sel(sel_p[p]), .mode(mode_p[p]), .sel_ok(ok_p[p]),
      .ptr(ptr_p[p]), .sp(ptrs_q[NPTR-1]), .offset(offset_q),
      .modifier(modifier_q), .short_addr(short_p[p]),
      .addr(addr_p[p]), .wr_en(wr_en[p]), .wr_idx(wr_idx[p]), .wr_val(wr_val[p])
    );
  end

  assign p0_addr = addr_p[0];
  assign p1_addr = addr_p[1];
endmodule

// File: rtl/dual_agu_checker.sv
module dual_agu_checker #(
  parameter int AW   = 16,
  parameter int NPTR = 5,
  parameter int SW   = 6,
  localparam int IW  = $clog2(NPTR),
  localparam int LW  = $clog2(NPTR + 2)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ld_en,
  input logic [LW-1:0]           ld_sel,
  input logic [AW-1:0]           ld_data,
  input logic                    p0_en,
  input logic [IW-1:0]           p0_sel,
  input logic [2:0]              p0_mode,
  input logic [SW-1:0]           p0_short,
  input logic                    p1_en,
  input logic [IW-1:0]           p1_sel,
  input logic [2:0]              p1_mode,
  input logic [AW-1:0]           p0_addr,
  input logic [AW-1:0]           p1_addr,
  input logic [NPTR-1:0][AW-1:0] ptrs,
  input logic [AW-1:0]           offset,
  input logic [AW-1:0]           modifier
);
  a_r2_load_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_sel < LW'(NPTR)) |=> ptrs[$past(ld_sel[IW-1:0])] == $past(ld_data));

  a_r3_postinc_p1: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_en && p1_mode == 3'd1 && p1_sel < IW'(NPTR) && !p0_en && !ld_en)
    |=> ptrs[$past(p1_sel)] == $past(p1_addr) + 1'b1);

  a_r4_indexed: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_en && p0_mode == 3'd4 && p0_sel < IW'(NPTR))
    |-> p0_addr == ptrs[p0_sel] + offset);

  a_r5_push: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_en && p1_mode == 3'd5 && !p0_en && !ld_en)
    |=> ptrs[NPTR-1] == $past(p1_addr));

  a_r6_short: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_en && p0_mode == 3'd7) |-> p0_addr == AW'(p0_short));

  a_r9_port0_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_en && p1_en && p0_sel == p1_sel && p0_sel < IW'(NPTR) && p0_mode == 3'd1 &&
     p1_mode == 3'd2 && modifier == '1 && !ld_en)
    |=> ptrs[$past(p0_sel)] == $past(p0_addr) + 1'b1);

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!p0_en |-> p0_addr == '0) and (!p1_en |-> p1_addr == '0));
endmodule

bind dual_agu dual_agu_checker #(.AW(AW), .NPTR(NPTR), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
  .p0_en(p0_en), .p0_sel(p0_sel), .p0_mode(p0_mode), .p0_short(p0_short),
  .p1_en(p1_en), .p1_sel(p1_sel), .p1_mode(p1_mode),
  .p0_addr(p0_addr), .p1_addr(p1_addr),
  .ptrs(ptrs_q), .offset(offset_q), .modifier(modifier_q)
);

// File: tb/test_dual_agu.sv
module test_dual_agu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_sel = '0;
  logic [15:0] ld_data = '0;
  logic        p0_en = 1'b0, p1_en = 1'b0;
  logic [2:0]  p0_sel = '0, p1_sel = '0, p0_mode = '0, p1_mode = '0;
  logic [5:0]  p0_short = '0, p1_short = '0;
  logic [15:0] p0_addr, p1_addr;

  int checks = 0;
  int errors = 0;
  int mp[5];
  int moff = 0;
  int mmod = 65535;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_agu i_dual_agu (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .p0_en(p0_en), .p0_sel(p0_sel), .p0_mode(p0_mode), .p0_short(p0_short),
    .p1_en(p1_en), .p1_sel(p1_sel), .p1_mode(p1_mode), .p1_short(p1_short),
    .p0_addr(p0_addr), .p1_addr(p1_addr)
  );

  function automatic int signed_off();
    return (moff >= 32768) ? moff - 65536 : moff;
  endfunction

  function automatic int next_ptr(int p, int mode, int port);
    int d, mask, nr;
    d = (mode == 1) ? 1 : (mode == 2) ? -1 : signed_off();
    if (port == 1 || mmod == 65535) return (p + d) & 65535;
    mask = 0;
    while (mask < mmod) mask = mask * 2 + 1;
    nr = (p & mask) + d;
    if (nr > mmod) nr -= mmod + 1;
    else if (nr < 0) nr += mmod + 1;
    return (p & ~mask & 65535) | (nr & mask);
  endfunction

  function automatic int exp_addr(logic en, int sel, int mode, int sh);
    if (!en) return 0;
    case (mode)
      0, 1, 2, 3: return (sel < 5) ? mp[sel] : 0;
      4:          return (sel < 5) ? (mp[sel] + moff) & 65535 : 0;
      5:          return (mp[4] - 1) & 65535;
      6:          return mp[4];
      default:    return sh;
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_update();
    int op[5];
    int np[5];
    for (int i = 0; i < 5; i++) begin op[i] = mp[i]; np[i] = mp[i]; end
    for (int port = 1; port >= 0; port--) begin
      logic en;
      int sel, mode;
      en   = (port == 0) ? p0_en : p1_en;
      sel  = (port == 0) ? int'(p0_sel) : int'(p1_sel);
      mode = (port == 0) ? int'(p0_mode) : int'(p1_mode);
      if (en) begin
        if (mode >= 1 && mode <= 3 && sel < 5) np[sel] = next_ptr(op[sel], mode, port);
        else if (mode == 5) np[4] = (op[4] - 1) & 65535;
        else if (mode == 6) np[4] = (op[4] + 1) & 65535;
      end
    end
    if (ld_en) begin
      if (ld_sel < 5) np[ld_sel] = int'(ld_data);
      else if (ld_sel == 5) moff = int'(ld_data);
      else if (ld_sel == 6) mmod = int'(ld_data);
    end
    for (int i = 0; i < 5; i++) mp[i] = np[i];
  endtask

  // compare both ports on this cycle, then advance one clock
  task automatic step(string req);
    #1;
    check(req, "p0_addr", int'(p0_addr), exp_addr(p0_en, int'(p0_sel), int'(p0_mode), int'(p0_short)));
    check(req, "p1_addr", int'(p1_addr), exp_addr(p1_en, int'(p1_sel), int'(p1_mode), int'(p1_short)));
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    ld_en = 0; p0_en = 0; p1_en = 0;
  endtask

  task automatic drive0(int sel, int mode, int sh);
    p0_en = 1; p0_sel = 3'(sel); p0_mode = 3'(mode); p0_short = 6'(sh);
  endtask

  task automatic drive1(int sel, int mode, int sh);
    p1_en = 1; p1_sel = 3'(sel); p1_mode = 3'(mode); p1_short = 6'(sh);
  endtask

  task automatic load(int sel, int data, string req);
    idle(); ld_en = 1; ld_sel = 3'(sel); ld_data = 16'(data);
    step(req);
    ld_en = 0;
  endtask

  task automatic read_all(string req);
    for (int i = 0; i < 5; i++) begin
      idle(); drive0(i, 0, 0); drive1(i, 4, 0); step(req);
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) mp[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset contents; R10: idle ports give zero
    idle(); step("R1_R10");
    read_all("R1");
    idle(); drive0(0, 1, 0); step("R1");   // modifier 0xFFFF -> linear

    // R2: loads, ignored code 7
    for (int i = 0; i < 5; i++) load(i, 16'h1000 + i * 16'h0111, "R2");
    load(5, 3, "R2");
    read_all("R2");
    load(7, 16'hBEEF, "R2");
    read_all("R2");
    // R2: load beats a port update
    idle(); drive0(2, 1, 0); ld_en = 1; ld_sel = 2; ld_data = 16'h4444; step("R2");
    read_all("R2");

    // R3: post-modify on both ports; R11 both in one cycle
    idle(); drive0(0, 1, 0); drive1(1, 2, 0); step("R3_R11");
    idle(); drive0(1, 3, 0); drive1(0, 3, 0); step("R3");
    load(5, 16'hFFFE, "R3");
    idle(); drive0(3, 3, 0); drive1(3, 0, 0); step("R3");
    read_all("R3");

    // R4: indexed, no update
    idle(); drive0(2, 4, 0); drive1(3, 4, 0); step("R4");
    read_all("R4");

    // R5: push and pop ignore select
    load(4, 16'h0100, "R5");
    idle(); drive1(7, 5, 0); step("R5");
    idle(); drive0(2, 5, 0); step("R5");
    idle(); drive1(0, 6, 0); step("R5");
    idle(); drive0(0, 6, 0); step("R5");
    read_all("R5");
    load(4, 0, "R5");
    idle(); drive0(1, 5, 0); step("R5");   // wraps 0 -> 0xFFFF
    read_all("R5");

    // R6: short direct and plain leave state alone
    idle(); drive0(3, 7, 6'h3F); drive1(1, 7, 6'h05); step("R6");
    read_all("R6");

    // R7: circular buffer of 10 on port 0
    load(0, 16'h1238, "R7");
    load(6, 9, "R7");
    load(5, 3, "R7");
    for (int k = 0; k < 3; k++) begin idle(); drive0(0, 1, 0); step("R7"); end
    idle(); drive0(0, 2, 0); step("R7");
    idle(); drive0(0, 2, 0); step("R7");
    idle(); drive0(0, 3, 0); step("R7");
    idle(); drive0(0, 3, 0); step("R7");
    load(5, 16'hFFFC, "R7");
    idle(); drive0(0, 3, 0); step("R7");
    idle(); drive0(0, 3, 0); step("R7");
    load(6, 0, "R7");
    idle(); drive0(0, 1, 0); step("R7");   // size-1 buffer: no motion
    read_all("R7");
    load(6, 9, "R7");

    // R8: port 1 linear despite modifier
    load(1, 16'h1239, "R8");
    idle(); drive1(1, 1, 0); step("R8");
    idle(); drive1(1, 3, 0); step("R8");
    read_all("R8");

    // R9: same pointer, port 0 kept
    load(6, 16'hFFFF, "R9");
    idle(); drive0(2, 1, 0); drive1(2, 2, 0); step("R9");
    idle(); drive0(3, 2, 0); drive1(3, 3, 0); step("R9");
    idle(); drive0(1, 6, 0); drive1(0, 5, 0); step("R9");
    read_all("R9");

    // R10: out-of-range selects
    idle(); drive0(5, 1, 0); drive1(6, 4, 0); step("R10");
    idle(); drive0(7, 3, 0); drive1(5, 0, 0); step("R10");
    read_all("R10");

    // R11: mixed traffic
    for (int n = 0; n < 3000; n++) begin
      idle();
      if ($urandom_range(0, 9) < 8) drive0($urandom_range(0, 6), $urandom_range(0, 7), $urandom_range(0, 63));
      if ($urandom_range(0, 9) < 8) drive1($urandom_range(0, 6), $urandom_range(0, 7), $urandom_range(0, 63));
      if ($urandom_range(0, 9) < 2) begin
        int s;
        s = $urandom_range(0, 7);
        ld_en = 1; ld_sel = 3'(s);
        if (s == 5)      ld_data = 16'($urandom_range(0, 8) - 4);
        else if (s == 6) ld_data = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom_range(0, 40));
        else             ld_data = 16'($urandom);
      end
      step("R11");
    end

    idle(); step("R11");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule